// File: doc/BRIEF.md
# Symmetric Decimating FIR Cell

This block is one eight-tap filter cell built around four multipliers. Each multiplier serves a pair of taps that share one coefficient. The two samples of a pair are summed by a pre-adder before the multiply. A forward delay line supplies one side of every pre-adder. A reverse delay line supplies the other side. The spacing between taps on both lines is a programmable decimation factor from 1 to 16.

The reverse line is fed from two 16-entry last-in-first-out buffers. One buffer collects the samples that enter the cell. The other plays its contents back into the reverse line, newest first. A transfer strobe exchanges the roles of the two buffers. Each side of the pre-adders can be forced to zero on its own. With both sides enabled, the cell computes a folded symmetric filter. With one side enabled, it computes a plain asymmetric one. The output is the raw sum of the four products on every clock. Accumulation, rounding and coefficient storage belong to the surrounding logic.

All datapath inputs are registered on the rising clock edge. The strobes are active low.

Top module: `symFirCell`

## Requirements
- R1: A synchronous active-high reset clears both delay lines, empties both buffers and drives `sumOut` to zero. While the strobes are idle (all high), `sumOut` stays zero.
- R2: The values presented on the inputs at one rising edge determine `sumOut` two rising edges later. Those values are the sample, the coefficients, the decimation select and the strobes.
- R3: With `decimSel` = v, the spacing is D = v+1. Forward tap k (k = 0..3) is the sample shifted in k·D shifts earlier, where k = 0 is the newest.
- R4: When `shiftN` is high, neither delay line nor either buffer changes.
- R5: When `fwdN` is high, the forward side of every pre-adder is zero. When it is low, the forward tap is used.
- R6: When `revN` is high, the reverse side of every pre-adder is zero. When it is low, reverse tap (3−k)·D is used for pair k.
- R7: Each shift writes the incoming sample into the collecting buffer. Once that buffer holds 16 entries, further samples are dropped.
- R8: Each shift pops the playback buffer, last written first, into the head of the reverse line. A pop from an empty buffer yields zero.
- R9: A low `transferN` swaps the buffers. The playback buffer then holds what was collected, and the collecting buffer starts empty. If a shift happens in the same cycle, the shift acts first with the old roles.
- R10: `sumOut` is the 23-bit signed sum over k of c_k·(fwdTap_k + revTap_k). The pre-add is 11-bit signed and each product is 21-bit signed, so no value wraps.
- R11: `coefIn` bits [10k+9:10k] carry signed coefficient c_k for pair k. Samples are 10-bit signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 10 | Signed input sample |
| coefIn | input | 40 | Four signed 10-bit coefficients, pair 0 in the low bits |
| decimSel | input | 4 | Decimation factor minus one |
| shiftN | input | 1 | Shift enable, active low |
| fwdN | input | 1 | Forward pre-adder input enable, active low |
| revN | input | 1 | Reverse pre-adder input enable, active low |
| transferN | input | 1 | Buffer swap, active low |
| sumOut | output | 23 | Signed sum of the four products |

## Verification
A shift and a buffer swap can land in the same cycle. In that cycle, the sample pushed into the collecting buffer must be among those played back after the swap. The pop must also come from the old playback buffer. Directed sequences place the transfer strobe both with and without a shift, after partial fills and after overflow. The random phase asserts transfer about one cycle in eight over a random shift pattern. A bench model of the two buffers and both lines predicts each output, and the output is compared two edges after the inputs are taken.

// File: rtl/firPkg.sv
package firPkg;
  // Strobes handed from control to datapath, all active high.
  // shift/xfer act on the lines and buffers one stage after capture;
  // fwdOn/revOn gate the pre-adders one stage later, aligned with the sum.
  typedef struct packed {
    logic shift;
    logic xfer;
    logic fwdOn;
    logic revOn;
  } firStrobes_t;
endpackage

// File: rtl/firCtrl.sv
module firCtrl
  import firPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        shiftN,
  input  logic        fwdN,
  input  logic        revN,
  input  logic        transferN,
  output firStrobes_t stb
);
  logic shiftQ, xferQ, fwdQ1, revQ1, fwdQ2, revQ2;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= 1'b0;
      xferQ  <= 1'b0;
      fwdQ1  <= 1'b0;
      revQ1  <= 1'b0;
      fwdQ2  <= 1'b0;
      revQ2  <= 1'b0;
    end else begin
      shiftQ <= ~shiftN;
      xferQ  <= ~transferN;
      fwdQ1  <= ~fwdN;
      revQ1  <= ~revN;
      fwdQ2  <= fwdQ1;
      revQ2  <= revQ1;
    end
  end

  always_comb begin
    stb.shift = shiftQ;
    stb.xfer  = xferQ;
    stb.fwdOn = fwdQ2;
    stb.revOn = revQ2;
  end

  // R4: a low shift enable at the pins becomes an active shift strobe
  assert_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !shiftN |=> stb.shift);
  // R5: forward gate follows the pin two edges later
  assert_fwd_gate_R5: assert property (@(posedge clk) disable iff (rst)
    fwdQ1 |=> stb.fwdOn);
endmodule

// File: rtl/firLifo.sv
module firLifo #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  input  logic              clear,
  output logic [DATA_W-1:0] popData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     topIdx;
  logic              canWrite;

  assign topIdx   = count - CW'(1);
  assign canWrite = push && (count < CW'(DEPTH));
  assign popData  = (count != '0) ? mem[topIdx[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (canWrite && !clear) mem[count[AW-1:0]] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)         count <= '0;
    else if (canWrite)        count <= count + CW'(1);
    else if (pop && count != '0) count <= count - CW'(1);
  end

  // R7: fill level never exceeds the depth
  assert_lifo_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R7: a push into a full buffer leaves it full
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (push && !clear && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));
  // R9: a cleared buffer is empty on the next cycle
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0));
endmodule

// File: rtl/firDatapath.sv
module firDatapath
  import firPkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int COEF_W    = 10,
  parameter int TAPS_HALF = 4,
  parameter int MAX_DECIM = 16,
  parameter int LIFO_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  firStrobes_t                     stb,
  input  logic [DATA_W-1:0]               sampleIn,
  input  logic [TAPS_HALF*COEF_W-1:0]     coefIn,
  input  logic [$clog2(MAX_DECIM)-1:0]    decimSel,
  output logic signed [DATA_W+COEF_W+$clog2(TAPS_HALF):0] sumOut
);
  localparam int PRE_W    = DATA_W + 1;
  localparam int PROD_W   = PRE_W + COEF_W;
  localparam int SUM_W    = PROD_W + $clog2(TAPS_HALF);
  localparam int DSEL_W   = $clog2(MAX_DECIM);
  localparam int LINE_LEN = (TAPS_HALF - 1) * MAX_DECIM + 1;
  localparam int IDX_W    = $clog2(LINE_LEN);
  localparam int CW       = $clog2(LIFO_DEPTH + 1);

  // input stage and alignment stage
  logic signed [DATA_W-1:0]       dinQ;
  logic [TAPS_HALF*COEF_W-1:0]    coefQ1, coefQ2;
  logic [DSEL_W-1:0]              decimQ1, decimQ2;

  always_ff @(posedge clk) begin
    if (rst) begin
      dinQ    <= '0;
      coefQ1  <= '0;
      coefQ2  <= '0;
      decimQ1 <= '0;
      decimQ2 <= '0;
    end else begin
      dinQ    <= sampleIn;
      coefQ1  <= coefIn;
      coefQ2  <= coefQ1;
      decimQ1 <= decimSel;
      decimQ2 <= decimQ1;
    end
  end

  // buffer pair: role names the collecting buffer
  logic                 role;
  logic [DATA_W-1:0]    popVec [2];
  logic [CW-1:0]        cntVec [2];
  logic signed [DATA_W-1:0] readData;
  logic [CW-1:0]        readCnt;

  for (genvar g = 0; g < 2; g++) begin : gLifo
    logic isWriter;
    assign isWriter = (role == 1'(g));
    firLifo #(.DATA_W(DATA_W), .DEPTH(LIFO_DEPTH)) lifo_i (
      .clk      (clk),
      .rst      (rst),
      .push     (stb.shift && isWriter),
      .pushData (dinQ),
      .pop      (stb.shift && !isWriter),
      .clear    (stb.xfer && !isWriter),
      .popData  (popVec[g]),
      .count    (cntVec[g])
    );
  end

  assign readData = role ? popVec[0] : popVec[1];
  assign readCnt  = role ? cntVec[0] : cntVec[1];

  always_ff @(posedge clk) begin
    if (rst)           role <= 1'b0;
    else if (stb.xfer) role <= ~role;
  end

  // forward and reverse decimation lines
  logic signed [DATA_W-1:0] fwdLine [LINE_LEN];
  logic signed [DATA_W-1:0] revLine [LINE_LEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINE_LEN; i++) begin
        fwdLine[i] <= '0;
        revLine[i] <= '0;
      end
    end else if (stb.shift) begin
      fwdLine[0] <= dinQ;
      revLine[0] <= readData;
      for (int i = 1; i < LINE_LEN; i++) begin
        fwdLine[i] <= fwdLine[i-1];
        revLine[i] <= revLine[i-1];
      end
    end
  end

  // tap selection by decimation spacing
  logic signed [DATA_W-1:0] tapFwd [TAPS_HALF];
  logic signed [DATA_W-1:0] tapRev [TAPS_HALF];
  int dFac;
  logic [IDX_W-1:0] fIdx, rIdx;

  always_comb begin
    dFac = int'(decimQ2) + 1;
    fIdx = '0;
    rIdx = '0;
    for (int k = 0; k < TAPS_HALF; k++) begin
      fIdx = IDX_W'(k * dFac);
      rIdx = IDX_W'((TAPS_HALF - 1 - k) * dFac);
      tapFwd[k] = fwdLine[fIdx];
      tapRev[k] = revLine[rIdx];
    end
  end

  // pre-add and multiply, one pair per coefficient
  logic signed [PROD_W-1:0] prodVec [TAPS_HALF];

  for (genvar k = 0; k < TAPS_HALF; k++) begin : gPair
    logic signed [PRE_W-1:0]  preSum;
    logic signed [COEF_W-1:0] coefK;
    logic signed [PRE_W-1:0]  sideA, sideB;
    assign coefK  = coefQ2[k*COEF_W +: COEF_W];
    assign sideA  = stb.fwdOn ? PRE_W'(tapFwd[k]) : '0;
    assign sideB  = stb.revOn ? PRE_W'(tapRev[k]) : '0;
    assign preSum = sideA + sideB;
    assign prodVec[k] = PROD_W'(preSum) * PROD_W'(coefK);
  end

  logic signed [SUM_W-1:0] total;
  always_comb begin
    total = '0;
    for (int k = 0; k < TAPS_HALF; k++) total = total + SUM_W'(prodVec[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) sumOut <= '0;
    else     sumOut <= total;
  end

  // R4: without a shift the line heads hold
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !stb.shift |=> ($stable(fwdLine[0]) && $stable(revLine[0])));
  // R5 and R6: both pre-adder sides gated off yields a zero sum
  assert_gates_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!stb.fwdOn && !stb.revOn) |=> (sumOut == '0));
  // R8: a pop from an empty playback buffer loads zero
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (stb.shift && readCnt == '0) |=> (revLine[0] == '0));
  // R9: a transfer exchanges the buffer roles
  assert_swap_R9: assert property (@(posedge clk) disable iff (rst)
    stb.xfer |=> (role != $past(role)));
endmodule

// File: rtl/symFirCell.sv
module symFirCell
  import firPkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int COEF_W     = 10,
  parameter int TAPS_HALF  = 4,
  parameter int MAX_DECIM  = 16,
  parameter int LIFO_DEPTH = 16
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [DATA_W-1:0]                             sampleIn,
  input  logic [TAPS_HALF*COEF_W-1:0]                   coefIn,
  input  logic [$clog2(MAX_DECIM)-1:0]                  decimSel,
  input  logic                                          shiftN,
  input  logic                                          fwdN,
  input  logic                                          revN,
  input  logic                                          transferN,
  output logic signed [DATA_W+COEF_W+$clog2(TAPS_HALF):0] sumOut
);
  firStrobes_t stb;

  firCtrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .shiftN    (shiftN),
    .fwdN      (fwdN),
    .revN      (revN),
    .transferN (transferN),
    .stb       (stb)
  );

  firDatapath #(
    .DATA_W     (DATA_W),
    .COEF_W     (COEF_W),
    .TAPS_HALF  (TAPS_HALF),
    .MAX_DECIM  (MAX_DECIM),
    .LIFO_DEPTH (LIFO_DEPTH)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .sampleIn (sampleIn),
    .coefIn   (coefIn),
    .decimSel (decimSel),
    .sumOut   (sumOut)
  );
endmodule

// File: tb/symFirCell_tb.sv
module symFirCell_tb_top;
  localparam int LINE = 49;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  sampleIn = '0;
  logic [39:0] coefIn = '0;
  logic [3:0]  decimSel = '0;
  logic        shiftN = 1'b1, fwdN = 1'b1, revN = 1'b1, transferN = 1'b1;
  logic signed [22:0] sumOut;

  always #5 clk = ~clk;

  symFirCell dut_i (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .coefIn(coefIn),
    .decimSel(decimSel), .shiftN(shiftN), .fwdN(fwdN), .revN(revN),
    .transferN(transferN), .sumOut(sumOut)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // bench model state
  int mF [LINE];
  int mV [LINE];
  int lw [16];
  int lr [16];
  int wc, rc;
  int    pExp [3];
  bit    pVal [3];
  string pTag [3];

  function automatic int sx10(input logic [9:0] v);
    return int'($signed(v));
  endfunction

  task automatic modelReset();
    for (int i = 0; i < LINE; i++) begin mF[i] = 0; mV[i] = 0; end
    wc = 0; rc = 0;
  endtask

  // applies one set of inputs to the model, returns the expected sum
  function automatic int modelStep();
    int d, popped, s, a, b;
    d = int'(decimSel) + 1;
    if (!shiftN) begin
      popped = 0;
      if (rc > 0) begin popped = lr[rc-1]; rc--; end
      if (wc < 16) begin lw[wc] = sx10(sampleIn); wc++; end
      for (int i = LINE-1; i > 0; i--) begin mF[i] = mF[i-1]; mV[i] = mV[i-1]; end
      mF[0] = sx10(sampleIn);
      mV[0] = popped;
    end
    if (!transferN) begin
      for (int i = 0; i < 16; i++) lr[i] = lw[i];
      rc = wc; wc = 0;
    end
    s = 0;
    for (int k = 0; k < 4; k++) begin
      a = fwdN ? 0 : mF[k*d];
      b = revN ? 0 : mV[(3-k)*d];
      s += sx10(coefIn[k*10 +: 10]) * (a + b);
    end
    return s;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: sumOut actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge with inputs already set
  task automatic cycle(input string tag);
    if (pVal[2]) check(pTag[2], int'(sumOut), pExp[2]);
    pExp[2] = pExp[1]; pVal[2] = pVal[1]; pTag[2] = pTag[1];
    pExp[1] = pExp[0]; pVal[1] = pVal[0]; pTag[1] = pTag[0];
    pExp[0] = modelStep(); pVal[0] = 1'b1; pTag[0] = tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [9:0] din, input logic [39:0] c, input logic [3:0] ds,
                       input logic sN, input logic fN, input logic rN, input logic xN,
                       input string tag);
    sampleIn = din; coefIn = c; decimSel = ds;
    shiftN = sN; fwdN = fN; revN = rN; transferN = xN;
    cycle(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive('0, coefIn, decimSel, 1, 1, 1, 1, tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    sampleIn = '0; shiftN = 1; fwdN = 1; revN = 1; transferN = 1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    modelReset();
    rst = 1'b0;
    // R1: output is zero right after reset and for the idle pipeline
    check("R1", int'(sumOut), 0);
    for (int i = 0; i < 3; i++) begin pExp[i] = 0; pVal[i] = 1'b1; pTag[i] = "R1"; end
  endtask

  function automatic logic [39:0] pack4(input int c0, input int c1, input int c2, input int c3);
    return {10'(c3), 10'(c2), 10'(c1), 10'(c0)};
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [39:0] cf;
    void'($urandom(32'h5EED_F1C7));
    @(negedge clk);
    doReset();
    idle(4, "R1");

    // R3 and R11: impulse through forward taps, spacing 1, distinct coefs
    cf = pack4(1, 2, 3, 4);
    drive(10'd5, cf, 4'd0, 0, 0, 1, 1, "R3");
    for (int i = 0; i < 6; i++) drive('0, cf, 4'd0, 0, 0, 1, 1, "R11");

    // R3: widest spacing
    doReset();
    drive(10'd7, cf, 4'd15, 0, 0, 1, 1, "R3");
    for (int i = 0; i < 52; i++) drive('0, cf, 4'd15, 0, 0, 1, 1, "R3");

    // R4: hold while shift high, gates on
    doReset();
    for (int i = 0; i < 5; i++) drive(10'(i * 3 + 1), cf, 4'd0, 0, 0, 0, 1, "R4");
    for (int i = 0; i < 6; i++) drive(10'h3FF, cf, 4'd0, 1, 0, 0, 1, "R4");

    // R5 and R6: gate combinations on held data
    drive('0, cf, 4'd0, 1, 1, 0, 1, "R5");
    drive('0, cf, 4'd0, 1, 0, 1, 1, "R6");
    drive('0, cf, 4'd0, 1, 1, 1, 1, "R6");

    // R8: pops from empty playback buffer give zero
    doReset();
    for (int i = 0; i < 8; i++) drive(10'(i + 20), cf, 4'd1, 0, 1, 0, 1, "R8");

    // R7: overflow collecting buffer, swap, play back 18
    doReset();
    for (int i = 0; i < 20; i++) drive(10'(i + 1), cf, 4'd0, 0, 1, 1, 1, "R7");
    drive('0, cf, 4'd0, 1, 1, 1, 0, "R9");
    for (int i = 0; i < 18; i++) drive(10'(100 + i), pack4(1, 0, 0, 0), 4'd0, 0, 1, 0, 1, "R7");
    idle(3, "R8");

    // R9: transfer together with shift after a partial fill
    doReset();
    for (int i = 0; i < 3; i++) drive(10'(i + 40), cf, 4'd0, 0, 1, 1, 1, "R9");
    drive(10'd50, cf, 4'd0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 8; i++) drive('0, pack4(0, 0, 0, 1), 4'd0, 0, 1, 0, 1, "R9");

    // R10: extremes, both sides at most negative
    doReset();
    cf = pack4(-512, -512, -512, -512);
    for (int i = 0; i < 5; i++) drive(10'h200, cf, 4'd0, 0, 0, 0, 1, "R10");
    drive('0, cf, 4'd0, 1, 1, 1, 0, "R10");
    for (int i = 0; i < 10; i++) drive(10'h200, cf, 4'd0, 0, 0, 0, 1, "R10");
    idle(3, "R10");

    // R2 and R10: constrained random traffic
    doReset();
    for (int blk = 0; blk < 20; blk++) begin
      logic [3:0] ds;
      ds = 4'($urandom_range(0, 15));
      for (int i = 0; i < 200; i++) begin
        drive(10'($urandom), {10'($urandom), 10'($urandom), 10'($urandom), 10'($urandom)},
              ds, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0),
              1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 7) != 0), "R2");
      end
    end
    idle(3, "R10");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule